// File: doc/BRIEF.md
# BCH Error Location Applier

This block takes the error bit locations that an external BCH locator has found for one 512-byte sector and applies them. Each location is flipped either in the sector data buffer or in the stored ECC bytes kept beside it, using read-modify-write accesses on two synchronous buffer ports. Two code strengths are supported. The 8-bit mode uses 14 ECC bytes, of which the last is reserved. The 16-bit mode uses 26 ECC bytes.

A job starts with a `start_i` pulse. The block then captures the mode, the computed syndrome bytes and the stored ECC bytes. It first screens the sector:
- A syndrome that is all zero means the sector is clean.
- Stored ECC that is all 0xFF means the page is erased.

In both cases the job ends at once with zero corrections. Otherwise the block presents the syndrome in reversed byte order to the locator. It then consumes error locations from a valid/ready stream, one every three cycles, until a location with the last flag arrives or sixteen have been taken.

Locations count bits backwards from the end of the combined data-plus-ECC codeword. A location that falls before the start of that codeword is reported as a failure, and the remaining locations are still applied.

Top module: `bch_loc_apply`

## Requirements
- R1: When every active computed syndrome byte is 0x00 (bytes 0..13 in mode 0, bytes 0..25 in mode 1), `done_o` rises two cycles after the start cycle. No location is accepted, no buffer is written, `fixed_cnt_o` is 0 and `fail_o` is 0. Bytes above the active count are ignored.
- R2: When the syndrome is not clean but every active stored ECC byte is 0xFF, the job ends as in R1 with 0 corrections and no failure.
- R3: While locations are being accepted, `rev_valid_o` is high. Byte i of `rev_syn_o` (bits 8i+7..8i) is defined as follows:
  - In mode 1, it is syndrome byte 25−i.
  - In mode 0, it is syndrome byte 12−i for i<13, and syndrome byte 13 unchanged for i=13.
  - Bytes above the active count are zero.
  - `loc_ready_o` is only high while `rev_valid_o` is high.
- R4: The codeword limit is 512+13 in mode 0 (`mode_i`=0) and 512+26 in mode 1. For a location L, the byte position is limit − floor(L/8) − 1 and the bit index is L mod 8.
- R5: A byte position below 512 inverts bit (L mod 8) of sector byte at that address: the read is followed by a write of the read value XOR (1 << bit).
- R6: A byte position from 512 to limit−1 inverts the same bit of ECC byte (position − 512).
- R7: A negative byte position causes no buffer access and sets `fail_o`. Locations after it in the same job are still applied.
- R8: At `done_o`, `fixed_cnt_o` equals the number of locations applied to a buffer.
- R9: At most 16 locations are taken per job. After the sixteenth, the job ends even without the last flag, and `loc_ready_o` stays low.
- R10: An applied location occupies three cycles (accept, read, write), and at most one buffer access occurs per cycle. An out-of-range location occupies one cycle.
- R11: Mode, syndrome and stored ECC are sampled in the start cycle. Later changes on those inputs, and `start_i` pulses while busy, have no effect on the job.
- R12: `done_o` is a one-cycle pulse. `fail_o` and `fixed_cnt_o` hold their values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a job (accepted only when idle) |
| mode_i | input | 1 | 0: 8-bit strength, 14 ECC bytes; 1: 16-bit strength, 26 ECC bytes |
| calc_syn_i | input | 208 | Computed syndrome, byte i at bits 8i+7..8i |
| stored_ecc_i | input | 208 | ECC bytes read from the spare area, byte i at bits 8i+7..8i |
| busy_o | output | 1 | A job is in progress |
| rev_valid_o | output | 1 | Reversed syndrome valid, locations being accepted |
| rev_syn_o | output | 208 | Byte-reversed syndrome for the locator |
| loc_valid_i | input | 1 | Location stream valid |
| loc_ready_o | output | 1 | Location stream ready |
| loc_i | input | 13 | Error bit location |
| loc_last_i | input | 1 | Marks the final location of the job |
| sec_rd_o | output | 1 | Sector buffer read strobe |
| sec_wr_o | output | 1 | Sector buffer write strobe |
| sec_addr_o | output | 9 | Sector buffer byte address |
| sec_wdata_o | output | 8 | Sector buffer write data |
| sec_rdata_i | input | 8 | Sector buffer read data, one cycle after the read strobe |
| ecc_rd_o | output | 1 | ECC buffer read strobe |
| ecc_wr_o | output | 1 | ECC buffer write strobe |
| ecc_addr_o | output | 5 | ECC buffer byte address |
| ecc_wdata_o | output | 8 | ECC buffer write data |
| ecc_rdata_i | input | 8 | ECC buffer read data, one cycle after the read strobe |
| done_o | output | 1 | One-cycle end-of-job pulse |
| fail_o | output | 1 | Job saw an out-of-range location |
| fixed_cnt_o | output | 5 | Number of locations applied |

## Verification
The hardest situations to reach are the boundaries of the position arithmetic: the exact location where a flip moves from the ECC bytes into the sector, and the first location whose position goes negative. Both differ between the modes because of the reserved byte. The stimulus sweeps every location from 0 past eight times the limit in both modes, in consecutive batches of varying length, so each boundary and the last-flag and sixteen-location endings are crossed. The sixteen-location cap without a last flag is reached by holding an extra location on the stream after the sixteenth and confirming that it is never taken. The screens are driven with a location already offered, to show that nothing is consumed.

// File: rtl/apl_pkg.sv
package apl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCREEN,
        ST_TAKE,
        ST_READ,
        ST_WRITE,
        ST_FINISH
    } apl_state_e;

endpackage

// File: rtl/apl_screen.sv
// Clean / erased detection over the active byte count of the selected mode.
module apl_screen #(
    parameter int BCH8_BYTES  = 14,
    parameter int BCH16_BYTES = 26,
    parameter int ECC_MAX     = BCH16_BYTES,
    localparam int SYN_W      = ECC_MAX * 8
) (
    input  logic             mode_i,
    input  logic [SYN_W-1:0] syn_i,
    input  logic [SYN_W-1:0] stored_i,
    output logic             clean_o,
    output logic             erased_o
);

    logic [ECC_MAX-1:0] zero_ok;
    logic [ECC_MAX-1:0] ff_ok;

    for (genvar i = 0; i < ECC_MAX; i++) begin : g_byte
        logic active;
        assign active   = mode_i ? (i < BCH16_BYTES) : (i < BCH8_BYTES);
        assign zero_ok[i] = !active || (syn_i[i*8 +: 8] == 8'h00);
        assign ff_ok[i]   = !active || (stored_i[i*8 +: 8] == 8'hFF);
    end

    assign clean_o  = &zero_ok;
    assign erased_o = &ff_ok;

endmodule

// File: rtl/apl_reverse.sv
// Byte-order reversal of the syndrome; the reserved byte of the short mode
// stays in place.
module apl_reverse #(
    parameter int BCH8_BYTES  = 14,
    parameter int BCH16_BYTES = 26,
    parameter int ECC_MAX     = BCH16_BYTES,
    localparam int SYN_W      = ECC_MAX * 8
) (
    input  logic             mode_i,
    input  logic [SYN_W-1:0] syn_i,
    output logic [SYN_W-1:0] rev_o
);

    for (genvar i = 0; i < ECC_MAX; i++) begin : g_byte
        logic [7:0] short_b;
        logic [7:0] long_b;
        if (i < BCH8_BYTES - 1) begin : g_s_rev
            assign short_b = syn_i[(BCH8_BYTES-2-i)*8 +: 8];
        end else if (i == BCH8_BYTES - 1) begin : g_s_keep
            assign short_b = syn_i[i*8 +: 8];
        end else begin : g_s_zero
            assign short_b = 8'h00;
        end
        if (i < BCH16_BYTES) begin : g_l_rev
            assign long_b = syn_i[(BCH16_BYTES-1-i)*8 +: 8];
        end else begin : g_l_zero
            assign long_b = 8'h00;
        end
        assign rev_o[i*8 +: 8] = mode_i ? long_b : short_b;
    end

endmodule

// File: rtl/apl_locmap.sv
// Maps a backward-counted bit location to a buffer target.
module apl_locmap #(
    parameter int SECTOR_BYTES = 512,
    parameter int BCH8_BYTES   = 14,
    parameter int BCH16_BYTES  = 26,
    parameter int LOC_W        = 13,
    localparam int SEC_AW      = $clog2(SECTOR_BYTES),
    localparam int ECC_AW      = $clog2(BCH16_BYTES),
    localparam int POS_W       = LOC_W + 2
) (
    input  logic              mode_i,
    input  logic [LOC_W-1:0]  loc_i,
    output logic              in_range_o,
    output logic              to_ecc_o,
    output logic [SEC_AW-1:0] sec_addr_o,
    output logic [ECC_AW-1:0] ecc_addr_o,
    output logic [2:0]        bit_o
);

    logic [POS_W-1:0] limit;
    logic [POS_W-1:0] pos;

    always_comb begin
        limit      = mode_i ? POS_W'(SECTOR_BYTES + BCH16_BYTES)
                            : POS_W'(SECTOR_BYTES + BCH8_BYTES - 1);
        pos        = limit - POS_W'(loc_i >> 3) - POS_W'(1);
        in_range_o = !pos[POS_W-1];
        to_ecc_o   = pos >= POS_W'(SECTOR_BYTES);
        sec_addr_o = pos[SEC_AW-1:0];
        ecc_addr_o = ECC_AW'(pos - POS_W'(SECTOR_BYTES));
        bit_o      = loc_i[2:0];
    end

endmodule

// File: rtl/bch_loc_apply.sv
module bch_loc_apply
    import apl_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int BCH8_BYTES   = 14,
    parameter int BCH16_BYTES  = 26,
    parameter int LOC_W        = 13,
    parameter int MAX_LOCS     = 16,
    localparam int ECC_MAX     = BCH16_BYTES,
    localparam int SYN_W       = ECC_MAX * 8,
    localparam int SEC_AW      = $clog2(SECTOR_BYTES),
    localparam int ECC_AW      = $clog2(BCH16_BYTES),
    localparam int CNT_W       = $clog2(MAX_LOCS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [SYN_W-1:0]  calc_syn_i,
    input  logic [SYN_W-1:0]  stored_ecc_i,
    output logic              busy_o,
    output logic              rev_valid_o,
    output logic [SYN_W-1:0]  rev_syn_o,
    input  logic              loc_valid_i,
    output logic              loc_ready_o,
    input  logic [LOC_W-1:0]  loc_i,
    input  logic              loc_last_i,
    output logic              sec_rd_o,
    output logic              sec_wr_o,
    output logic [SEC_AW-1:0] sec_addr_o,
    output logic [7:0]        sec_wdata_o,
    input  logic [7:0]        sec_rdata_i,
    output logic              ecc_rd_o,
    output logic              ecc_wr_o,
    output logic [ECC_AW-1:0] ecc_addr_o,
    output logic [7:0]        ecc_wdata_o,
    input  logic [7:0]        ecc_rdata_i,
    output logic              done_o,
    output logic              fail_o,
    output logic [CNT_W-1:0]  fixed_cnt_o
);

    typedef struct packed {
        apl_state_e        st;
        logic              mode;
        logic [SYN_W-1:0]  syn;
        logic [SYN_W-1:0]  stored;
        logic              to_ecc;
        logic [SEC_AW-1:0] sec_addr;
        logic [ECC_AW-1:0] ecc_addr;
        logic [2:0]        bit_idx;
        logic              fin;
        logic [CNT_W-1:0]  taken;
        logic [CNT_W-1:0]  fixed;
        logic              bad;
    } apl_regs_t;

    apl_regs_t q, d;

    logic              clean, erased;
    logic              map_ok, map_ecc;
    logic [SEC_AW-1:0] map_sec_addr;
    logic [ECC_AW-1:0] map_ecc_addr;
    logic [2:0]        map_bit;
    logic              end_now;
    logic [7:0]        flip_mask;

    apl_screen #(
        .BCH8_BYTES (BCH8_BYTES),
        .BCH16_BYTES(BCH16_BYTES),
        .ECC_MAX    (ECC_MAX)
    ) i_screen (
        .mode_i  (q.mode),
        .syn_i   (q.syn),
        .stored_i(q.stored),
        .clean_o (clean),
        .erased_o(erased)
    );

    apl_reverse #(
        .BCH8_BYTES (BCH8_BYTES),
        .BCH16_BYTES(BCH16_BYTES),
        .ECC_MAX    (ECC_MAX)
    ) i_reverse (
        .mode_i(q.mode),
        .syn_i (q.syn),
        .rev_o (rev_syn_o)
    );

    apl_locmap #(
        .SECTOR_BYTES(SECTOR_BYTES),
        .BCH8_BYTES  (BCH8_BYTES),
        .BCH16_BYTES (BCH16_BYTES),
        .LOC_W       (LOC_W)
    ) i_locmap (
        .mode_i    (q.mode),
        .loc_i     (loc_i),
        .in_range_o(map_ok),
        .to_ecc_o  (map_ecc),
        .sec_addr_o(map_sec_addr),
        .ecc_addr_o(map_ecc_addr),
        .bit_o     (map_bit)
    );

    always_comb begin
        d       = q;
        end_now = loc_last_i || (q.taken == CNT_W'(MAX_LOCS - 1));
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.st     = ST_SCREEN;
                    d.mode   = mode_i;
                    d.syn    = calc_syn_i;
                    d.stored = stored_ecc_i;
                    d.taken  = '0;
                    d.fixed  = '0;
                    d.bad    = 1'b0;
                end
            end
            ST_SCREEN: begin
                d.st = (clean || erased) ? ST_FINISH : ST_TAKE;
            end
            ST_TAKE: begin
                if (loc_valid_i) begin
                    d.taken = q.taken + CNT_W'(1);
                    if (!map_ok) begin
                        d.bad = 1'b1;
                        if (end_now) begin
                            d.st = ST_FINISH;
                        end
                    end else begin
                        d.to_ecc   = map_ecc;
                        d.sec_addr = map_sec_addr;
                        d.ecc_addr = map_ecc_addr;
                        d.bit_idx  = map_bit;
                        d.fin      = end_now;
                        d.st       = ST_READ;
                    end
                end
            end
            ST_READ: begin
                d.st = ST_WRITE;
            end
            ST_WRITE: begin
                d.fixed = q.fixed + CNT_W'(1);
                d.st    = q.fin ? ST_FINISH : ST_TAKE;
            end
            ST_FINISH: begin
                d.st = ST_IDLE;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    always_comb begin
        flip_mask   = 8'h01 << q.bit_idx;
        busy_o      = (q.st != ST_IDLE);
        rev_valid_o = (q.st == ST_TAKE) || (q.st == ST_READ) || (q.st == ST_WRITE);
        loc_ready_o = (q.st == ST_TAKE);
        sec_rd_o    = (q.st == ST_READ)  && !q.to_ecc;
        ecc_rd_o    = (q.st == ST_READ)  &&  q.to_ecc;
        sec_wr_o    = (q.st == ST_WRITE) && !q.to_ecc;
        ecc_wr_o    = (q.st == ST_WRITE) &&  q.to_ecc;
        sec_addr_o  = q.sec_addr;
        ecc_addr_o  = q.ecc_addr;
        sec_wdata_o = sec_rdata_i ^ flip_mask;
        ecc_wdata_o = ecc_rdata_i ^ flip_mask;
        done_o      = (q.st == ST_FINISH);
        fail_o      = q.bad;
        fixed_cnt_o = q.fixed;
    end

endmodule

// File: rtl/bch_loc_apply_chk.sv
module bch_loc_apply_chk #(
    parameter int SECTOR_BYTES = 512,
    parameter int BCH16_BYTES  = 26,
    parameter int MAX_LOCS     = 16,
    localparam int SYN_W       = BCH16_BYTES * 8,
    localparam int SEC_AW      = $clog2(SECTOR_BYTES),
    localparam int ECC_AW      = $clog2(BCH16_BYTES),
    localparam int CNT_W       = $clog2(MAX_LOCS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rev_valid_o,
    input logic [SYN_W-1:0]  rev_syn_o,
    input logic              loc_ready_o,
    input logic              sec_rd_o,
    input logic              sec_wr_o,
    input logic [SEC_AW-1:0] sec_addr_o,
    input logic [7:0]        sec_wdata_o,
    input logic [7:0]        sec_rdata_i,
    input logic              ecc_rd_o,
    input logic              ecc_wr_o,
    input logic [ECC_AW-1:0] ecc_addr_o,
    input logic [7:0]        ecc_wdata_o,
    input logic [7:0]        ecc_rdata_i,
    input logic              done_o,
    input logic [CNT_W-1:0]  fixed_cnt_o
);

    p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sec_rd_o, sec_wr_o, ecc_rd_o, ecc_wr_o}));

    p_read_then_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_rd_o || ecc_rd_o) |=> (sec_wr_o || ecc_wr_o));

    p_sec_rmw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr_o |-> ($past(sec_rd_o) && (sec_addr_o == $past(sec_addr_o))));

    p_sec_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sec_wr_o |-> ($countones(sec_wdata_o ^ sec_rdata_i) == 1));

    p_ecc_rmw_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_wr_o |-> ($past(ecc_rd_o) && (ecc_addr_o == $past(ecc_addr_o))));

    p_ecc_flip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_wr_o |-> ($countones(ecc_wdata_o ^ ecc_rdata_i) == 1));

    p_ecc_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_rd_o |-> (ecc_addr_o < ECC_AW'(BCH16_BYTES)));

    p_ready_locate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ready_o |-> rev_valid_o);

    p_rev_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rev_valid_o && $past(rev_valid_o)) |-> $stable(rev_syn_o));

    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_cnt_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fixed_cnt_o <= CNT_W'(MAX_LOCS));

endmodule

bind bch_loc_apply bch_loc_apply_chk #(
    .SECTOR_BYTES(SECTOR_BYTES),
    .BCH16_BYTES (BCH16_BYTES),
    .MAX_LOCS    (MAX_LOCS)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rev_valid_o(rev_valid_o),
    .rev_syn_o  (rev_syn_o),
    .loc_ready_o(loc_ready_o),
    .sec_rd_o   (sec_rd_o),
    .sec_wr_o   (sec_wr_o),
    .sec_addr_o (sec_addr_o),
    .sec_wdata_o(sec_wdata_o),
    .sec_rdata_i(sec_rdata_i),
    .ecc_rd_o   (ecc_rd_o),
    .ecc_wr_o   (ecc_wr_o),
    .ecc_addr_o (ecc_addr_o),
    .ecc_wdata_o(ecc_wdata_o),
    .ecc_rdata_i(ecc_rdata_i),
    .done_o     (done_o),
    .fixed_cnt_o(fixed_cnt_o)
);

// File: tb/test_bch_loc_apply.sv
`timescale 1ns/1ps
module test_bch_loc_apply;

    localparam int SECB  = 512;
    localparam int NE    = 26;
    localparam int SYN_W = NE * 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             mode_i = 1'b0;
    logic [SYN_W-1:0] calc_syn_i = '0;
    logic [SYN_W-1:0] stored_ecc_i = '0;
    logic             busy_o, rev_valid_o;
    logic [SYN_W-1:0] rev_syn_o;
    logic             loc_valid_i = 1'b0;
    logic             loc_ready_o;
    logic [12:0]      loc_i = '0;
    logic             loc_last_i = 1'b0;
    logic             sec_rd_o, sec_wr_o, ecc_rd_o, ecc_wr_o;
    logic [8:0]       sec_addr_o;
    logic [4:0]       ecc_addr_o;
    logic [7:0]       sec_wdata_o, ecc_wdata_o;
    logic [7:0]       sec_rdata_i = '0, ecc_rdata_i = '0;
    logic             done_o, fail_o;
    logic [4:0]       fixed_cnt_o;

    always #2.5 clk = ~clk;

    bch_loc_apply i_bch_loc_apply (.*);

    logic [7:0] sec_mem [SECB];
    logic [7:0] ecc_mem [NE];
    logic [7:0] exp_sec [SECB];
    logic [7:0] exp_ecc [NE];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SECB; i++) sec_mem[i] <= 8'((i * 7 + 3) & 255);
            for (int i = 0; i < NE; i++)   ecc_mem[i] <= 8'((i * 11 + 5) & 255);
        end else begin
            if (sec_rd_o) sec_rdata_i <= sec_mem[sec_addr_o];
            if (sec_wr_o) sec_mem[sec_addr_o] <= sec_wdata_o;
            if (ecc_rd_o) ecc_rdata_i <= ecc_mem[ecc_addr_o];
            if (ecc_wr_o) ecc_mem[ecc_addr_o] <= ecc_wdata_o;
        end
    end

    int checks = 0;
    int errors = 0;
    int job_loc [17];
    logic [SYN_W-1:0] syn_v, sto_v;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [SYN_W-1:0] exp_rev(input bit m, input logic [SYN_W-1:0] s);
        logic [SYN_W-1:0] r = '0;
        for (int i = 0; i < NE; i++) begin
            if (m) r[i*8 +: 8] = s[(25 - i)*8 +: 8];
            else if (i < 13) r[i*8 +: 8] = s[(12 - i)*8 +: 8];
            else if (i == 13) r[i*8 +: 8] = s[i*8 +: 8];
        end
        return r;
    endfunction

    // n locations from job_loc; use_last marks the n-th; locate=0 means a screen ends the job
    task automatic run_job(input bit m, input int n, input bit use_last, input bit locate,
                           input string req);
        int lim, cnt, wt, gap, mism, first_bad;
        bit bad, timing_ok, prev_valid, saw_ready;
        lim = m ? SECB + 26 : SECB + 13;
        cnt = 0; bad = 0;
        if (locate) begin
            for (int k = 0; k < n; k++) begin
                int pos, b;
                pos = lim - job_loc[k] / 8 - 1;
                b = job_loc[k] % 8;
                if (pos < 0) bad = 1;
                else if (pos < SECB) begin exp_sec[pos] ^= 8'(1 << b); cnt++; end
                else begin exp_ecc[pos - SECB] ^= 8'(1 << b); cnt++; end
            end
        end
        @(negedge clk);
        mode_i = m; calc_syn_i = syn_v; stored_ecc_i = sto_v; start_i = 1'b1;
        if (!locate) begin loc_valid_i = 1'b1; loc_i = 13'd8; loc_last_i = 1'b1; end
        @(negedge clk);
        start_i = 1'b0; mode_i = ~m; calc_syn_i = ~syn_v; stored_ecc_i = ~sto_v;
        saw_ready = 0;
        if (locate) begin
            wt = 0;
            while (!loc_ready_o && wt < 10) begin @(negedge clk); wt++; end
            chk(rev_valid_o && rev_syn_o == exp_rev(m, syn_v), "R3", "reversed syndrome",
                longint'(rev_syn_o[63:0]), longint'(exp_rev(m, syn_v) >> 0) & 64'hFFFFFFFFFFFFFFFF);
            timing_ok = 1; prev_valid = 0;
            for (int k = 0; k < n; k++) begin
                loc_valid_i = 1'b1; loc_i = 13'(job_loc[k]);
                loc_last_i = use_last && (k == n - 1);
                start_i = (k == 0);
                gap = 0;
                while (!loc_ready_o && gap < 20) begin @(negedge clk); gap++; end
                if (k > 0 && gap != (prev_valid ? 2 : 0)) timing_ok = 0;
                prev_valid = (lim - job_loc[k] / 8 - 1) >= 0;
                @(negedge clk);
                start_i = 1'b0;
            end
            if (!use_last) begin loc_valid_i = 1'b1; loc_i = '0; loc_last_i = 1'b0; end
            else loc_valid_i = 1'b0;
            chk(timing_ok, "R10", "accept spacing 3 cycles applied / 1 cycle invalid", timing_ok, 1);
        end
        wt = 0;
        while (!done_o && wt < 200) begin
            if (loc_ready_o) saw_ready = 1;
            @(negedge clk); wt++;
        end
        chk(done_o, "R8", "done seen", done_o, 1);
        if (!locate)
            chk(wt == 1 && !saw_ready, {req, " screen"}, "done latency / no accept", wt, 1);
        if (!use_last && locate) chk(!saw_ready, "R9", "no 17th accept", saw_ready, 0);
        chk(fixed_cnt_o == 5'(cnt), {req, " R8"}, "fixed count", fixed_cnt_o, cnt);
        chk(fail_o == bad, {req, " R7"}, "fail flag", fail_o, bad);
        @(negedge clk);
        loc_valid_i = 1'b0; loc_last_i = 1'b0;
        chk(!done_o && fixed_cnt_o == 5'(cnt) && fail_o == bad && !busy_o, "R12",
            "done pulse and held results", done_o, 0);
        mism = 0; first_bad = -1;
        for (int i = 0; i < SECB; i++) if (sec_mem[i] !== exp_sec[i]) begin mism++; if (first_bad < 0) first_bad = i; end
        for (int i = 0; i < NE; i++) if (ecc_mem[i] !== exp_ecc[i]) begin mism++; if (first_bad < 0) first_bad = SECB + i; end
        chk(mism == 0, {req, " R4 R5 R6"}, "buffer contents, first bad position", first_bad, -1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < SECB; i++) exp_sec[i] = 8'((i * 7 + 3) & 255);
        for (int i = 0; i < NE; i++)   exp_ecc[i] = 8'((i * 11 + 5) & 255);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy_o && !done_o && !loc_ready_o && !rev_valid_o && !fail_o && fixed_cnt_o == 0,
            "R12", "reset state", busy_o, 0);

        // R1: clean syndrome, long mode
        syn_v = '0; sto_v = '0;
        for (int i = 0; i < NE; i++) sto_v[i*8 +: 8] = 8'(i + 1);
        run_job(1'b1, 0, 1'b1, 1'b0, "R1");
        // R1: short mode ignores bytes above 13
        syn_v = '0;
        for (int i = 14; i < NE; i++) syn_v[i*8 +: 8] = 8'hA5;
        run_job(1'b0, 0, 1'b1, 1'b0, "R1");
        // R2: erased, long mode
        syn_v = '0; syn_v[7:0] = 8'h3C; sto_v = '1;
        run_job(1'b1, 0, 1'b1, 1'b0, "R2");
        // R2: erased short mode, inactive stored bytes not FF
        sto_v = '0;
        for (int i = 0; i < 14; i++) sto_v[i*8 +: 8] = 8'hFF;
        run_job(1'b0, 0, 1'b1, 1'b0, "R2");

        // R1: reserved byte 13 nonzero is not clean in short mode
        syn_v = '0; syn_v[13*8 +: 8] = 8'h01; sto_v = '0;
        job_loc[0] = 3;
        run_job(1'b0, 1, 1'b1, 1'b1, "R1");
        // R2: one stored byte not FF (byte 25) in long mode is not erased
        syn_v = '0; syn_v[0 +: 8] = 8'h11; sto_v = '1; sto_v[25*8 +: 8] = 8'hFE;
        job_loc[0] = 4300; job_loc[1] = 4296;
        run_job(1'b1, 2, 1'b1, 1'b1, "R2");

        // R7: mix of out-of-range and valid locations
        for (int i = 0; i < NE; i++) syn_v[i*8 +: 8] = 8'(i * 5 + 9);
        sto_v = '0;
        job_loc[0] = 8191; job_loc[1] = 4; job_loc[2] = 5000; job_loc[3] = 4300; job_loc[4] = 4207;
        run_job(1'b1, 5, 1'b1, 1'b1, "R7");
        job_loc[0] = 4200; job_loc[1] = 4199; job_loc[2] = 4103; job_loc[3] = 4096;
        run_job(1'b0, 4, 1'b1, 1'b1, "R7");

        // R9: sixteen without a last flag, seventeenth held on the stream
        for (int k = 0; k < 16; k++) job_loc[k] = 100 + k * 9;
        run_job(1'b0, 16, 1'b0, 1'b1, "R9");

        // R4 R5 R6 R11: sweep every location in both modes
        for (int m = 0; m < 2; m++) begin
            int lim8, base, batch;
            lim8 = (m == 1 ? SECB + 26 : SECB + 13) * 8;
            base = 0; batch = 0;
            while (base < lim8 + 40) begin
                int n;
                n = 16 - (batch % 4);
                for (int i = 0; i < NE; i++) begin
                    syn_v[i*8 +: 8] = 8'((batch * 13 + i * 7 + 1) & 255);
                    sto_v[i*8 +: 8] = 8'((i * 29 + batch) & 255);
                end
                sto_v[7:0] = 8'(batch & 127);
                syn_v[7:0] = 8'h80 | 8'(batch & 127);
                for (int k = 0; k < n; k++) job_loc[k] = base + k;
                run_job(m[0], n, 1'b1, 1'b1, "R11");
                base += n; batch++;
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule